// File: doc/BRIEF.md
# Flash Region Access Checker

This block stands between three bus masters and a serial flash controller. Each master issues read and write requests against one flat flash address space. The checker admits one request at a time, decides whether that request is allowed, and forwards allowed requests to the flash controller with a chip select for one of two flash devices and an address local to that device. A denied request never reaches the flash. It returns a one-cycle error to its master and is logged in a sticky violation record.

Right after reset the checker reads the first 32-bit word of device 0 through the same flash port. Protection is enabled only when that word holds the expected signature, which puts the block in descriptor mode. In descriptor mode every address is mapped to one of five regions, and each master carries its own read and write permission bit for each region. Without the signature, only the host master may reach the flash. Region bounds, permissions and the size of device 0 are loaded through a small write-only register port. Region 0 is fixed and covers only the first 4 KB page.

Top module: `flash_region_guard`

## Requirements
- R1: After reset the block issues one read of device 0 at address 0 (fl_valid high, fl_cs = 2'b01, fl_addr = 0, fl_we low) and keeps req_ready at zero until fl_done ends that read.
- R2: desc_mode goes high only if fl_rdata equals 32'h0FF0A55A when the boot read completes. Any other value leaves it low, and desc_mode then stays unchanged until the next reset.
- R3: Pages are 4 KB, so the page number is addr[ADDR_W-1:12]. Region 0 is exactly page 0. Region k (1 to 4) is loaded at cfg_addr k, with the base page in cfg_wdata[11:0] and the limit page in cfg_wdata[27:16]. It covers base to limit inclusive and is disabled when limit < base. The lowest-numbered matching region wins. An address in no region gets region code 7 and is denied in descriptor mode.
- R4: Master m (0 = host, 1 = network, 2 = management) takes its permissions from cfg_addr 5+m. Read bits are cfg_wdata[4:0] and write bits are cfg_wdata[12:8], with bit r belonging to region r. In descriptor mode a request is allowed only if the bit for its direction and region is set.
- R5: While lock_desc is high, every write that maps to region 0 is denied, whatever the write bits say.
- R6: cfg_addr 8 sets the size of device 0 in pages (cfg_wdata[11:0]). If the page is below that size, fl_cs = 2'b01 and fl_addr = addr. Otherwise fl_cs = 2'b10 and fl_addr = addr minus the device 0 size in bytes. fl_cs is zero whenever fl_valid is low.
- R7: A denied request causes no flash access. resp_err for the requesting master goes high for exactly one cycle, in the cycle after acceptance.
- R8: The first denial after reset sets viol_flag and stores viol_master (the master ID) and viol_region (the region code, 7 when there is no region or the block is not in descriptor mode). Later denials leave all three outputs unchanged.
- R9: When not in descriptor mode, every host request is allowed and every request from the other masters is denied.
- R10: Only one request is outstanding at a time. req_ready is at most one-hot. When several masters are valid, the management master is granted first, then the host, then the network master.
- R11: An allowed request holds fl_valid until fl_done. In the fl_done cycle resp_done pulses for the requesting master and resp_rdata carries fl_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| lock_desc | input | 1 | Makes region 0 read-only for all masters |
| req_valid | input | 3 | Request valid, one bit per master |
| req_ready | output | 3 | Request accepted, one bit per master |
| req_write | input | 3 | Request is a write, per master |
| req_addr | input | 3*ADDR_W | Request byte address, master m at bits m*ADDR_W upward |
| req_wdata | input | 96 | Write data, master m at bits m*32 upward |
| resp_done | output | 3 | Completion pulse, per master |
| resp_err | output | 3 | Denial pulse, per master |
| resp_rdata | output | 32 | Read data valid with resp_done |
| fl_valid | output | 1 | Flash access pending |
| fl_cs | output | 2 | Device chip selects |
| fl_we | output | 1 | Flash access is a write |
| fl_addr | output | ADDR_W | Address within the selected device |
| fl_wdata | output | 32 | Flash write data |
| fl_done | input | 1 | Flash access finished |
| fl_rdata | input | 32 | Flash read data, valid with fl_done |
| desc_mode | output | 1 | Signature matched, protection active |
| viol_flag | output | 1 | Sticky denial flag |
| viol_master | output | 2 | Master of the first denial |
| viol_region | output | 3 | Region code of the first denial |

## Verification
The assertions assume that the flash side raises fl_done only while fl_valid is high and for a single cycle. They also assume that a master holds its request fields stable while its valid bit is high, and that configuration writes happen only while no request is pending. The bench flash model answers each access exactly once after a fixed latency. The bench master raises valid on a falling edge and drops it right after the edge at which it sees ready. Configuration is written only between transactions, so the lock input and the tables never change while the checker is deciding on a request.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    localparam int NUM_MST     = 3;
    localparam int NUM_RGN     = 5;
    localparam int RGN_W       = 3;
    localparam int DATA_W      = 32;
    localparam int PAGE_SHIFT  = 12;
    localparam int CFG_AW      = 4;

    // configuration register layout
    localparam int CFG_PERM_BASE = 5;
    localparam int CFG_DEV0      = 8;
    localparam int WR_FIELD_LSB  = 8;
    localparam int LIM_FIELD_LSB = 16;

    localparam logic [DATA_W-1:0] DESC_SIGNATURE = 32'h0FF0A55A;
    localparam logic [RGN_W-1:0]  RGN_DESC = 3'd0;
    localparam logic [RGN_W-1:0]  RGN_NONE = 3'd7;

    typedef enum logic [1:0] {
        MST_HOST = 2'd0,
        MST_NET  = 2'd1,
        MST_MGMT = 2'd2
    } master_e;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_IDLE,
        ST_BUSY,
        ST_DENY
    } guard_state_e;

    typedef struct packed {
        logic             allow;
        logic [RGN_W-1:0] region;
        logic             dev1;
    } verdict_t;

    function automatic logic perm_ok(
        input logic               desc,
        input master_e            mst,
        input logic               wr,
        input logic [RGN_W-1:0]   rgn,
        input logic [NUM_RGN-1:0] rd_bits,
        input logic [NUM_RGN-1:0] wr_bits,
        input logic               lock
    );
        logic ok;
        if (!desc) begin
            ok = (mst == MST_HOST);
        end else if (rgn == RGN_NONE) begin
            ok = 1'b0;
        end else if (wr) begin
            ok = wr_bits[rgn] && !(lock && rgn == RGN_DESC);
        end else begin
            ok = rd_bits[rgn];
        end
        return ok;
    endfunction

endpackage

// File: rtl/fg_cfg_regs.sv
module fg_cfg_regs
    import flash_guard_pkg::*;
#(
    parameter int PG_W = 12,
    parameter logic [PG_W-1:0] DEV0_RST = PG_W'(1) << (PG_W - 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [PG_W-1:0]     rgn_base  [NUM_RGN],
    output logic [PG_W-1:0]     rgn_limit [NUM_RGN],
    output logic [NUM_RGN-1:0]  rd_perm   [NUM_MST],
    output logic [NUM_RGN-1:0]  wr_perm   [NUM_MST],
    output logic [PG_W-1:0]     dev0_pages
);

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_wdata;

    // region 0 is pinned to the first page
    assign rgn_base[0]  = '0;
    assign rgn_limit[0] = '0;

    for (genvar r = 1; r < NUM_RGN; r++) begin : g_rgn
        always_ff @(posedge clk) begin
            if (rst) begin
                rgn_base[r]  <= '1;
                rgn_limit[r] <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(r)) begin
                rgn_base[r]  <= cfg_wdata[PG_W-1:0];
                rgn_limit[r] <= cfg_wdata[LIM_FIELD_LSB +: PG_W];
            end
        end
    end

    for (genvar m = 0; m < NUM_MST; m++) begin : g_perm
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_perm[m] <= '0;
                wr_perm[m] <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(CFG_PERM_BASE + m)) begin
                rd_perm[m] <= cfg_wdata[NUM_RGN-1:0];
                wr_perm[m] <= cfg_wdata[WR_FIELD_LSB +: NUM_RGN];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dev0_pages <= DEV0_RST;
        end else if (cfg_we && cfg_addr == CFG_AW'(CFG_DEV0)) begin
            dev0_pages <= cfg_wdata[PG_W-1:0];
        end
    end

endmodule

// File: rtl/fg_region_decode.sv
module fg_region_decode
    import flash_guard_pkg::*;
#(
    parameter int PG_W = 12
) (
    input  logic [PG_W-1:0]  page,
    input  logic [PG_W-1:0]  rgn_base  [NUM_RGN],
    input  logic [PG_W-1:0]  rgn_limit [NUM_RGN],
    output logic [RGN_W-1:0] region
);

    logic [NUM_RGN-1:0] hit;

    for (genvar r = 0; r < NUM_RGN; r++) begin : g_hit
        assign hit[r] = (rgn_base[r] <= rgn_limit[r]) &&
                        (page >= rgn_base[r]) && (page <= rgn_limit[r]);
    end

    // lowest index takes precedence on overlap
    always_comb begin
        region = RGN_NONE;
        for (int r = NUM_RGN - 1; r >= 0; r--) begin
            if (hit[r]) region = RGN_W'(r);
        end
    end

endmodule

// File: rtl/fg_arbiter.sv
module fg_arbiter
    import flash_guard_pkg::*;
(
    input  logic [NUM_MST-1:0] valid,
    output logic [NUM_MST-1:0] grant,
    output master_e            gnt_id
);

    localparam master_e RANK [NUM_MST] = '{MST_MGMT, MST_HOST, MST_NET};

    always_comb begin
        gnt_id = MST_HOST;
        for (int i = NUM_MST - 1; i >= 0; i--) begin
            if (valid[RANK[i]]) gnt_id = RANK[i];
        end
        grant = (|valid) ? (NUM_MST'(1) << gnt_id) : '0;
    end

endmodule

// File: rtl/flash_region_guard.sv
module flash_region_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [3:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    input  logic                  lock_desc,
    input  logic [2:0]            req_valid,
    output logic [2:0]            req_ready,
    input  logic [2:0]            req_write,
    input  logic [3*ADDR_W-1:0]   req_addr,
    input  logic [95:0]           req_wdata,
    output logic [2:0]            resp_done,
    output logic [2:0]            resp_err,
    output logic [31:0]           resp_rdata,
    output logic                  fl_valid,
    output logic [1:0]            fl_cs,
    output logic                  fl_we,
    output logic [ADDR_W-1:0]     fl_addr,
    output logic [31:0]           fl_wdata,
    input  logic                  fl_done,
    input  logic [31:0]           fl_rdata,
    output logic                  desc_mode,
    output logic                  viol_flag,
    output logic [1:0]            viol_master,
    output logic [2:0]            viol_region
);

    localparam int PG_W = ADDR_W - PAGE_SHIFT;

    logic [PG_W-1:0]    rgn_base  [NUM_RGN];
    logic [PG_W-1:0]    rgn_limit [NUM_RGN];
    logic [NUM_RGN-1:0] rd_perm   [NUM_MST];
    logic [NUM_RGN-1:0] wr_perm   [NUM_MST];
    logic [PG_W-1:0]    dev0_pages;

    fg_cfg_regs #(.PG_W(PG_W)) i_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rgn_base(rgn_base), .rgn_limit(rgn_limit),
        .rd_perm(rd_perm), .wr_perm(wr_perm), .dev0_pages(dev0_pages)
    );

    logic [NUM_MST-1:0] grant;
    master_e            gnt_id;

    fg_arbiter i_arb (.valid(req_valid), .grant(grant), .gnt_id(gnt_id));

    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_wdata;
    logic              sel_write;
    logic [PG_W-1:0]   sel_page;
    logic [RGN_W-1:0]  sel_region;

    assign sel_addr  = req_addr[int'(gnt_id)*ADDR_W +: ADDR_W];
    assign sel_wdata = req_wdata[int'(gnt_id)*DATA_W +: DATA_W];
    assign sel_write = req_write[gnt_id];
    assign sel_page  = sel_addr[ADDR_W-1:PAGE_SHIFT];

    fg_region_decode #(.PG_W(PG_W)) i_dec (
        .page(sel_page), .rgn_base(rgn_base), .rgn_limit(rgn_limit),
        .region(sel_region)
    );

    verdict_t          verdict;
    logic [ADDR_W-1:0] dev_offset;

    always_comb begin
        verdict.allow  = perm_ok(desc_mode, gnt_id, sel_write, sel_region,
                                 rd_perm[gnt_id], wr_perm[gnt_id], lock_desc);
        verdict.region = desc_mode ? sel_region : RGN_NONE;
        verdict.dev1   = (sel_page >= dev0_pages);
        dev_offset     = verdict.dev1 ?
                         (sel_addr - {dev0_pages, {PAGE_SHIFT{1'b0}}}) : sel_addr;
    end

    guard_state_e      state_q;
    master_e           cur_q;
    logic [1:0]        cs_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept;

    assign accept    = (state_q == ST_IDLE) && (|req_valid);
    assign req_ready = accept ? grant : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_BOOT;
            cur_q       <= MST_HOST;
            cs_q        <= 2'b01;
            addr_q      <= '0;
            we_q        <= 1'b0;
            wdata_q     <= '0;
            desc_mode   <= 1'b0;
            viol_flag   <= 1'b0;
            viol_master <= '0;
            viol_region <= '0;
        end else begin
            case (state_q)
                ST_BOOT: begin
                    if (fl_done) begin
                        desc_mode <= (fl_rdata == DESC_SIGNATURE);
                        state_q   <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (accept) begin
                        cur_q <= gnt_id;
                        if (verdict.allow) begin
                            cs_q    <= verdict.dev1 ? 2'b10 : 2'b01;
                            addr_q  <= dev_offset;
                            we_q    <= sel_write;
                            wdata_q <= sel_wdata;
                            state_q <= ST_BUSY;
                        end else begin
                            state_q <= ST_DENY;
                            if (!viol_flag) begin
                                viol_flag   <= 1'b1;
                                viol_master <= gnt_id;
                                viol_region <= verdict.region;
                            end
                        end
                    end
                end
                ST_BUSY: begin
                    if (fl_done) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign fl_valid   = (state_q == ST_BOOT) || (state_q == ST_BUSY);
    assign fl_cs      = fl_valid ? cs_q : 2'b00;
    assign fl_we      = we_q;
    assign fl_addr    = addr_q;
    assign fl_wdata   = wdata_q;
    assign resp_done  = (state_q == ST_BUSY && fl_done) ? (3'b001 << cur_q) : 3'b000;
    assign resp_err   = (state_q == ST_DENY) ? (3'b001 << cur_q) : 3'b000;
    assign resp_rdata = fl_rdata;

    // ---------------- assertions ----------------
    assert_no_ready_in_boot_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOOT) |-> (req_ready == 3'b000));

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_BOOT && $past(state_q) != ST_BOOT) |-> $stable(desc_mode));

    assert_locked_desc_R5: assert property (@(posedge clk) disable iff (rst)
        (fl_valid && fl_we && lock_desc && desc_mode && $stable(lock_desc)
         && state_q == ST_BUSY && $past(state_q) == ST_IDLE)
        |-> !(fl_cs == 2'b01 && fl_addr[ADDR_W-1:PAGE_SHIFT] == '0));

    assert_cs_select_R6: assert property (@(posedge clk) disable iff (rst)
        fl_valid ? $onehot(fl_cs) : (fl_cs == 2'b00));

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (|resp_err) |=> (resp_err == 3'b000));

    assert_deny_no_flash_R7: assert property (@(posedge clk) disable iff (rst)
        (|resp_err) |-> !fl_valid);

    assert_viol_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        viol_flag |=> (viol_flag && $stable(viol_master) && $stable(viol_region)));

    assert_host_only_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY && !desc_mode) |-> (cur_q == MST_HOST));

    assert_single_grant_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (|resp_done) |-> ($onehot(resp_done) && fl_valid));

endmodule

// File: tb/test_flash_region_guard.sv
`timescale 1ns/1ps
module test_flash_region_guard;

    localparam int AW = 24;
    localparam logic [31:0] SIG = 32'h0FF0A55A;

    logic clk = 0;
    logic rst = 1;
    logic cfg_we = 0;
    logic [3:0] cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic lock_desc = 0;
    logic [2:0] req_valid = 0;
    logic [2:0] req_ready;
    logic [2:0] req_write = 0;
    logic [3*AW-1:0] req_addr = 0;
    logic [95:0] req_wdata = 0;
    logic [2:0] resp_done, resp_err;
    logic [31:0] resp_rdata;
    logic fl_valid, fl_we;
    logic [1:0] fl_cs;
    logic [AW-1:0] fl_addr;
    logic [31:0] fl_wdata;
    logic fl_done = 0;
    logic [31:0] fl_rdata = 0;
    logic desc_mode, viol_flag;
    logic [1:0] viol_master;
    logic [2:0] viol_region;

    always #5 clk = ~clk;

    flash_region_guard #(.ADDR_W(AW)) i_flash_region_guard (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .lock_desc(lock_desc), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_done(resp_done), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .fl_valid(fl_valid), .fl_cs(fl_cs), .fl_we(fl_we), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_done(fl_done), .fl_rdata(fl_rdata),
        .desc_mode(desc_mode), .viol_flag(viol_flag), .viol_master(viol_master),
        .viol_region(viol_region)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [31:0] boot_word = 0;
    int wcnt = 0;
    int fl_count = 0;
    logic [1:0] cap_cs;
    logic [AW-1:0] cap_addr;
    logic cap_we;
    logic [31:0] cap_wdata;

    always @(negedge clk) begin
        fl_done <= 1'b0;
        if (rst) begin
            wcnt <= 0;
        end else if (fl_valid && !fl_done) begin
            if (wcnt == 2) begin
                fl_done   <= 1'b1;
                fl_rdata  <= (fl_cs == 2'b01 && fl_addr == 0 && !fl_we) ? boot_word
                                                                        : {8'hC3, fl_addr};
                cap_cs    <= fl_cs;
                cap_addr  <= fl_addr;
                cap_we    <= fl_we;
                cap_wdata <= fl_wdata;
                fl_count  <= fl_count + 1;
                wcnt      <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // ---------------- bench model of configuration ----------------
    int m_base [5];
    int m_lim  [5];
    logic [4:0] m_rd [3];
    logic [4:0] m_wr [3];
    int m_dev0 = 2048;
    bit m_desc = 0;
    bit ev_set = 0;
    int ev_m = 0;
    int ev_r = 0;

    task automatic model_reset();
        m_base[0] = 0; m_lim[0] = 0;
        for (int r = 1; r < 5; r++) begin m_base[r] = 4095; m_lim[r] = 0; end
        for (int m = 0; m < 3; m++) begin m_rd[m] = 0; m_wr[m] = 0; end
        m_dev0 = 2048;
        ev_set = 0;
    endtask

    task automatic cfg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
        if (a >= 1 && a <= 4) begin m_base[a] = int'(d[11:0]); m_lim[a] = int'(d[27:16]); end
        else if (a >= 5 && a <= 7) begin m_rd[a-5] = d[4:0]; m_wr[a-5] = d[12:8]; end
        else if (a == 8) m_dev0 = int'(d[11:0]);
    endtask

    function automatic int exp_region(input logic [AW-1:0] a);
        int pg = int'(a[AW-1:12]);
        if (pg == 0) return 0;
        for (int r = 1; r < 5; r++)
            if (m_base[r] <= m_lim[r] && pg >= m_base[r] && pg <= m_lim[r]) return r;
        return 7;
    endfunction

    task automatic do_reset(input logic [31:0] word, input string req);
        boot_word = word;
        rst = 1;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 0;
        req_valid = 3'b111;
        #1;
        // R1: boot read is on the flash port, masters are held off
        check(fl_valid === 1 && fl_cs === 2'b01 && fl_addr === 0 && fl_we === 0,
              "R1", "boot read cs", {30'd0, fl_cs}, 32'd1);
        @(negedge clk); #1;
        check(req_ready === 3'b000, "R1", "ready during boot", {29'd0, req_ready}, 0);
        req_valid = 0;
        repeat (6) @(negedge clk);
        #1;
        m_desc = (word == SIG);
        // R2: mode chosen by signature
        check(desc_mode === m_desc, req, "desc_mode", {31'd0, desc_mode}, {31'd0, m_desc});
        check(viol_flag === 0, "R8", "viol clear after reset", {31'd0, viol_flag}, 0);
    endtask

    task automatic do_req(input int m, input bit we, input logic [AW-1:0] a);
        int rg;
        bit ok;
        bit dev1;
        logic [AW-1:0] off;
        int cnt0;
        bit got_done, got_err;
        logic [31:0] rdat;
        string tag;
        rg = m_desc ? exp_region(a) : 7;
        if (!m_desc) begin ok = (m == 0); tag = "R9"; end
        else if (rg == 7) begin ok = 0; tag = "R3"; end
        else if (we && lock_desc && rg == 0) begin ok = 0; tag = "R5"; end
        else begin ok = we ? m_wr[m][rg] : m_rd[m][rg]; tag = "R4"; end
        dev1 = int'(a[AW-1:12]) >= m_dev0;
        off = dev1 ? a - AW'(m_dev0 * 4096) : a;
        cnt0 = fl_count;
        @(negedge clk);
        req_valid[m] = 1;
        req_write[m] = we;
        req_addr[m*AW +: AW] = a;
        req_wdata[m*32 +: 32] = {8'h77, a};
        #1;
        while (req_ready[m] !== 1'b1) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid[m] = 0;
        got_done = 0; got_err = 0; rdat = 0;
        while (!got_done && !got_err) begin
            @(negedge clk); #1;
            if (resp_done[m]) begin got_done = 1; rdat = resp_rdata; end
            if (resp_err[m]) got_err = 1;
        end
        check(got_done == ok && got_err == !ok, tag, $sformatf("allow m=%0d we=%0d a=%h", m, we, a),
              {31'd0, got_done}, {31'd0, ok});
        if (ok && got_done) begin
            // R6: device split
            check(cap_cs === (dev1 ? 2'b10 : 2'b01) && cap_addr === off, "R6",
                  $sformatf("route a=%h", a), {6'd0, cap_cs, cap_addr}, {6'd0, dev1 ? 2'b10 : 2'b01, off});
            if (we) check(cap_we === 1 && cap_wdata === {8'h77, a}, "R11", "write data",
                          cap_wdata, {8'h77, a});
            else    check(cap_we === 0 && rdat === {8'hC3, off}, "R11", "read data",
                          rdat, {8'hC3, off});
        end
        if (!ok) begin
            // R7: no flash activity for a denied request, single-cycle error
            check(fl_count == cnt0, "R7", "deny reached flash", fl_count, cnt0);
            @(negedge clk); #1;
            check(resp_err === 3'b000, "R7", "err width", {29'd0, resp_err}, 0);
            if (!ev_set) begin ev_set = 1; ev_m = m; ev_r = rg; end
        end
        check(viol_flag === ev_set && (!ev_set || (viol_master === 2'(ev_m) && viol_region === 3'(ev_r))),
              "R8", "violation record", {27'd0, viol_flag, viol_master, viol_region},
              {27'd0, ev_set, 2'(ev_m), 3'(ev_r)});
    endtask

    task automatic sweep();
        int pages [11] = '{0, 1, 7, 8, 15, 16, 19, 20, 24, 27, 28};
        for (int m = 0; m < 3; m++)
            for (int w = 0; w < 2; w++)
                for (int p = 0; p < 11; p++)
                    do_req(m, w[0], AW'(pages[p] * 4096 + 'h3A4));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // non-descriptor mode: wrong signature
        do_reset(32'h0FF0A55B, "R2");
        do_req(0, 0, 24'h123456);           // R9 host read, device 0
        do_req(0, 1, 24'h9000AB);           // R9 host write, device 1
        do_req(2, 0, 24'h000010);           // R9 management denied
        do_req(1, 1, 24'h400000);           // R9 network denied, record stays
        do_req(0, 0, 24'h7FFFFC);           // R6 last page of device 0

        // descriptor mode
        do_reset(SIG, "R2");
        cfg_write(8, 32'd16);
        cfg_write(1, {4'd0, 12'd7, 4'd0, 12'd1});
        cfg_write(2, {4'd0, 12'd15, 4'd0, 12'd8});
        cfg_write(3, {4'd0, 12'd19, 4'd0, 12'd16});
        cfg_write(4, {4'd0, 12'd27, 4'd0, 12'd24});
        cfg_write(5, {19'd0, 5'b00010, 3'd0, 5'b10011});
        cfg_write(6, {19'd0, 5'b01000, 3'd0, 5'b11001});
        cfg_write(7, {19'd0, 5'b00101, 3'd0, 5'b00111});
        lock_desc = 0;
        sweep();                            // R3 R4 R6
        lock_desc = 1;
        sweep();                            // R5
        lock_desc = 0;

        // R3 overlap: region 4 over part of region 3, lower index wins
        cfg_write(4, {4'd0, 12'd19, 4'd0, 12'd18});
        do_req(1, 1, AW'(18 * 4096 + 8));
        // R3 disabled region: limit below base
        cfg_write(4, {4'd0, 12'd24, 4'd0, 12'd25});
        do_req(1, 0, AW'(24 * 4096 + 8));
        do_req(1, 0, AW'(25 * 4096 + 8));

        // R10 fixed priority with all three valid
        begin
            int order [3] = '{2, 0, 1};
            @(negedge clk);
            for (int m = 0; m < 3; m++) begin
                req_write[m] = 0;
                req_addr[m*AW +: AW] = AW'(4096 + 16);
            end
            req_valid = 3'b111;
            for (int k = 0; k < 3; k++) begin
                #1;
                while (req_ready === 3'b000) begin @(negedge clk); #1; end
                check(req_ready === (3'b001 << order[k]), "R10", "grant order",
                      {29'd0, req_ready}, {29'd0, 3'b001 << order[k]});
                @(posedge clk); #1;
                req_valid[order[k]] = 0;
                @(negedge clk);
            end
            repeat (8) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule